// File: doc/BRIEF.md
# Direct-Mapped Flash Read Cache

This block sits between a processor fetch port and an embedded flash array that needs wait states. It holds 64 lines of 64 bits each, for 512 bytes in total. Each line is picked directly by a slice of the byte address and carries one valid bit. A hit returns the whole line one cycle after the request is taken. A miss reads the line from the array, stretched by a programmable number of wait states, and then places it in its slot.

Only the main program array, at the bottom of the address space, is cached. Every other address, including the data-flash window, goes straight to the array and never takes a line. The cache comes out of reset switched off. Software turns it on by loading a configuration word whose disable bit is 0. The same word sets a two-bit operating mode and the wait-state count.

All lines can be dropped at once in two ways: by an explicit invalidate command, or by a pulse that the flash controller raises on every page program or row erase. A fill that is in flight when either arrives still answers its requester, but it leaves its line invalid.

Top module: `flash_rcache`

## Requirements
- R1: After reset the cache is disabled, the mode is 0, the wait-state count is 0, `req_ready` is 1, and `rsp_valid` and `fl_rd` are 0.
- R2: While disabled, every read is fetched from the array, answers with `rsp_hit`=0, and neither consults nor updates any line.
- R3: The byte address splits into bits [2:0] as the offset (ignored; the whole 64-bit line is returned), bits [8:3] as the line index and bits [31:9] as the tag. `fl_addr` always has bits [2:0] at zero.
- R4: When enabled in mode 0, a read whose line is valid with a matching tag raises `rsp_valid` with `rsp_hit`=1 one cycle after acceptance, and does not read the array.
- R5: A read that is fetched from the array holds `fl_rd` high for ws+1 cycles and `req_ready` low while it runs. It answers ws+2 cycles after acceptance with `rsp_hit`=0 and the array data. In mode 0 the line is then valid under the new tag.
- R6: Addresses at or above 0x10000 (the data-flash window and everything outside the main array) are always fetched and never allocate a line.
- R7: A fill replaces whatever line held the same index, so the previous address at that index misses afterwards.
- R8: A one-cycle `inv_all` pulse clears every valid bit.
- R9: A one-cycle `nvm_mod` pulse clears every valid bit, so reads after a flash change return the new content.
- R10: If `inv_all` or `nvm_mod` arrives while a fetch is in flight, the requester still receives the correct data, but the line stays invalid.
- R11: Mode 1 (no-allocate) serves hits in one cycle, while misses are fetched without taking a line.
- R12: Mode 2 (fixed latency) answers hits after ws+2 cycles with `rsp_hit`=1 and without reading the array. Misses allocate as in mode 0.
- R13: Mode 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads the configuration word |
| cfg_dis | input | 1 | 1 = cache off, 0 = cache on |
| cfg_mode | input | 2 | 0 allocate, 1 no-allocate, 2 fixed latency, 3 as 0 |
| cfg_ws | input | WS_W | Array wait states |
| inv_all | input | 1 | Invalidate-all command pulse |
| nvm_mod | input | 1 | Pulse on page program or row erase |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Read byte address |
| req_ready | output | 1 | Request is taken when this and req_valid are high |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response was served from a line |
| rsp_data | output | 64 | Line data |
| fl_rd | output | 1 | Array read in progress |
| fl_addr | output | ADDR_W | Line-aligned array address |
| fl_rdata | input | 64 | Array read data |

## Verification
The bench drives several kinds of traffic: addresses that share an index but differ in tag, addresses on both sides of the main-array boundary, and invalidations timed to land inside a fill. A design that ignored the tag would return another address's data. One that allocated outside the main array would hit on data-flash reads. One that let a killed fill set its valid bit would hit on the next read of that line. Every `nvm_mod` pulse also changes the bench's flash content, so a missed invalidation shows up as stale data. Latency is measured per read against ws and mode, which exposes an off-by-one in the wait counter and a fixed-latency mode that answers early. A random run over a few aliasing lines, with varying wait states, compares every hit flag and data word against the bench's own cache model.

// File: rtl/frc_pkg.sv
package frc_pkg;
   typedef enum logic [1:0] {
      RM_ALLOC   = 2'd0,
      RM_NOALLOC = 2'd1,
      RM_FIXED   = 2'd2,
      RM_ALT     = 2'd3
   } rmode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } fstate_e;
endpackage

// File: rtl/frc_store.sv
module frc_store #(
   parameter int LINES  = 64,
   parameter int IDX_W  = 6,
   parameter int TAG_W  = 23,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   output logic [LINES-1:0]  valid_vec
);
   logic [TAG_W-1:0]  tag_all  [LINES];
   logic [DATA_W-1:0] data_all [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic              v_r;
      logic [TAG_W-1:0]  t_r;
      logic [DATA_W-1:0] d_r;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      v_r <= 1'b0;
         else if (clr)    v_r <= 1'b0;
         else if (sel)    v_r <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            t_r <= wr_tag;
            d_r <= wr_data;
         end
      end

      assign valid_vec[g] = v_r;
      assign tag_all[g]   = t_r;
      assign data_all[g]  = d_r;
   end

   assign rd_valid = valid_vec[rd_idx];
   assign rd_tag   = tag_all[rd_idx];
   assign rd_data  = data_all[rd_idx];
endmodule

// File: rtl/frc_ctrl.sv
module frc_ctrl
   import frc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 3,
   parameter int DATA_W = 64,
   parameter int WS_W   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic                    lookup_hit,
   input  logic                    cacheable,
   input  logic                    dis,
   input  rmode_e                  mode,
   input  logic [WS_W-1:0]         ws,
   input  logic                    inv,
   input  logic [DATA_W-1:0]       line_data,
   input  logic [DATA_W-1:0]       fl_rdata,
   output logic                    req_ready,
   output logic                    rsp_valid,
   output logic                    rsp_hit,
   output logic [DATA_W-1:0]       rsp_data,
   output logic                    fl_rd,
   output logic [ADDR_W-1:0]       fl_addr,
   output logic                    fill_en,
   output logic [ADDR_W-OFF_W-1:0] fill_line,
   output logic [DATA_W-1:0]       fill_data
);
   localparam int LINE_AW = ADDR_W - OFF_W;

   fstate_e             state;
   logic [WS_W-1:0]     cnt;
   logic                fetch_q, alloc_q, kill_q, hit_q;
   logic [DATA_W-1:0]   data_q;
   logic [LINE_AW-1:0]  line_q;

   logic accept, hit_now, fast, last, alloc_now;

   always_comb begin
      accept    = req_valid && (state == ST_IDLE);
      hit_now   = !dis && cacheable && lookup_hit;
      fast      = hit_now && (mode != RM_FIXED);
      alloc_now = !hit_now && !dis && cacheable && (mode != RM_NOALLOC);
      last      = (state == ST_WAIT) && (cnt == ws);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         fetch_q   <= 1'b0;
         alloc_q   <= 1'b0;
         kill_q    <= 1'b0;
         hit_q     <= 1'b0;
         data_q    <= '0;
         line_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (fast) begin
                     rsp_valid <= 1'b1;
                     rsp_hit   <= 1'b1;
                     rsp_data  <= line_data;
                  end else begin
                     state   <= ST_WAIT;
                     cnt     <= '0;
                     fetch_q <= !hit_now;
                     alloc_q <= alloc_now;
                     kill_q  <= 1'b0;
                     hit_q   <= hit_now;
                     data_q  <= line_data;
                     line_q  <= req_addr[ADDR_W-1:OFF_W];
                  end
               end
            end
            default: begin
               if (inv) kill_q <= 1'b1;
               if (last) begin
                  state     <= ST_IDLE;
                  rsp_valid <= 1'b1;
                  rsp_hit   <= hit_q;
                  rsp_data  <= fetch_q ? fl_rdata : data_q;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign fl_rd     = (state == ST_WAIT) && fetch_q;
   assign fl_addr   = {line_q, {OFF_W{1'b0}}};
   assign fill_en   = last && fetch_q && alloc_q && !kill_q && !inv;
   assign fill_line = line_q;
   assign fill_data = fl_rdata;
endmodule

// File: rtl/flash_rcache.sv
module flash_rcache
   import frc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINES      = 64,
   parameter int LINE_BYTES = 8,
   parameter int WS_W       = 2,
   parameter int MAIN_BYTES = 65536
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic                    cfg_dis,
   input  logic [1:0]              cfg_mode,
   input  logic [WS_W-1:0]         cfg_ws,
   input  logic                    inv_all,
   input  logic                    nvm_mod,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    req_ready,
   output logic                    rsp_valid,
   output logic                    rsp_hit,
   output logic [LINE_BYTES*8-1:0] rsp_data,
   output logic                    fl_rd,
   output logic [ADDR_W-1:0]       fl_addr,
   input  logic [LINE_BYTES*8-1:0] fl_rdata
);
   localparam int DATA_W = LINE_BYTES * 8;
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

   if ((1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two");
   end
   if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line_bytes
      $error("LINE_BYTES must be a power of two");
   end
   if (TAG_W < 1 || WS_W < 1) begin : g_bad_widths
      $error("address too narrow for geometry or WS_W below 1");
   end

   logic              dis_q;
   rmode_e            mode_q;
   logic [WS_W-1:0]   ws_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q  <= 1'b1;
         mode_q <= RM_ALLOC;
         ws_q   <= '0;
      end else if (cfg_we) begin
         dis_q  <= cfg_dis;
         mode_q <= rmode_e'(cfg_mode);
         ws_q   <= cfg_ws;
      end
   end

   logic                       inv_any, cacheable, lookup_hit;
   logic                       rd_valid;
   logic [TAG_W-1:0]           rd_tag;
   logic [DATA_W-1:0]          rd_data;
   logic [LINES-1:0]           valid_vec;
   logic                       fill_en;
   logic [ADDR_W-OFF_W-1:0]    fill_line;
   logic [DATA_W-1:0]          fill_data;

   assign inv_any    = inv_all | nvm_mod;
   assign cacheable  = (req_addr < ADDR_W'(MAIN_BYTES));
   assign lookup_hit = rd_valid && (rd_tag == req_addr[ADDR_W-1:OFF_W+IDX_W]);

   frc_store #(
      .LINES (LINES),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (inv_any),
      .wr_en    (fill_en),
      .wr_idx   (fill_line[IDX_W-1:0]),
      .wr_tag   (fill_line[ADDR_W-OFF_W-1:IDX_W]),
      .wr_data  (fill_data),
      .rd_idx   (req_addr[OFF_W+IDX_W-1:OFF_W]),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_data  (rd_data),
      .valid_vec(valid_vec)
   );

   frc_ctrl #(
      .ADDR_W(ADDR_W),
      .OFF_W (OFF_W),
      .DATA_W(DATA_W),
      .WS_W  (WS_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .lookup_hit(lookup_hit),
      .cacheable (cacheable),
      .dis       (dis_q),
      .mode      (mode_q),
      .ws        (ws_q),
      .inv       (inv_any),
      .line_data (rd_data),
      .fl_rdata  (fl_rdata),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .rsp_hit   (rsp_hit),
      .rsp_data  (rsp_data),
      .fl_rd     (fl_rd),
      .fl_addr   (fl_addr),
      .fill_en   (fill_en),
      .fill_line (fill_line),
      .fill_data (fill_data)
   );
endmodule

// File: rtl/frc_checker.sv
module frc_checker
   import frc_pkg::*;
#(
   parameter int LINES = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic             fl_rd,
   input logic             dis_q,
   input rmode_e           mode_q,
   input logic             lookup_hit,
   input logic             cacheable,
   input logic             inv_any,
   input logic [LINES-1:0] valid_vec
);
   assert_off_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_q && rsp_valid) |-> !rsp_hit);

   assert_fetch_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rd |-> !req_ready);

   assert_fast_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && lookup_hit && cacheable && !dis_q && mode_q == RM_ALLOC)
      |=> (rsp_valid && rsp_hit));

   assert_window_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !cacheable) |=> fl_rd);

   assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      inv_any |=> (valid_vec == '0));
endmodule

bind flash_rcache frc_checker #(.LINES(LINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .fl_rd     (fl_rd),
   .dis_q     (dis_q),
   .mode_q    (mode_q),
   .lookup_hit(lookup_hit),
   .cacheable (cacheable),
   .inv_any   (inv_any),
   .valid_vec (valid_vec)
);

// File: tb/flash_rcache_tb.sv
`timescale 1ns/1ps
module flash_rcache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_dis = 1'b0;
   logic [1:0]  cfg_mode = 2'd0, cfg_ws = 2'd0;
   logic        inv_all = 1'b0, nvm_mod = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready, rsp_valid, rsp_hit, fl_rd;
   logic [63:0] rsp_data, fl_rdata;
   logic [31:0] fl_addr;

   int total = 0, fails = 0, gen = 0;
   int m_dis = 1, m_mode = 0, m_ws = 0;
   int hits_model = 0, hits_dut = 0;
   bit in_txn = 1'b0;
   bit         mvalid [64];
   logic [22:0] mtag   [64];

   always #4 clk = ~clk;

   function automatic logic [63:0] pat(input logic [31:0] a, input int g);
      logic [28:0] l;
      l = a[31:3];
      return {l ^ 29'(g * 7919), 3'b101, ~l + 29'(g), 3'b010};
   endfunction

   assign fl_rdata = fl_rd ? pat(fl_addr, gen) : 64'hDEAD_BEEF_0BAD_F00D;

   flash_rcache u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dis(cfg_dis),
      .cfg_mode(cfg_mode), .cfg_ws(cfg_ws), .inv_all(inv_all), .nvm_mod(nvm_mod),
      .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
   );

   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   // per-clock comparison of the outputs that must be quiet between reads
   always @(negedge clk) begin
      #1;
      if (rst_n && rsp_valid && !in_txn) chk("R5", "unexpected rsp_valid", 1, 0);
      if (rst_n && fl_rd) chk("R3", "fl_addr offset bits", {61'd0, fl_addr[2:0]}, 0);
   end

   task automatic drop_model();
      for (int i = 0; i < 64; i++) mvalid[i] = 1'b0;
   endtask

   task automatic cfg(input int d, input int m, input int w);
      cfg_we = 1'b1; cfg_dis = d[0]; cfg_mode = m[1:0]; cfg_ws = w[1:0];
      @(negedge clk);
      cfg_we = 1'b0;
      m_dis = d; m_mode = m; m_ws = w;
   endtask

   task automatic pulse_inv(input bit prog);
      if (prog) nvm_mod = 1'b1; else inv_all = 1'b1;
      @(negedge clk);
      nvm_mod = 1'b0; inv_all = 1'b0;
      drop_model();
      if (prog) gen++;
   endtask

   task automatic rd(input logic [31:0] a, input bit kill, input string rq);
      logic [5:0]  idx;
      logic [22:0] tg;
      bit cach, ehit, alloc;
      int elat, efl, lat, nfl, mm;
      idx = a[8:3]; tg = a[31:9];
      cach = (a < 32'h10000);
      ehit = (m_dis == 0) && cach && mvalid[idx] && (mtag[idx] == tg);
      mm = (m_mode == 3) ? 0 : m_mode;
      elat = (ehit && mm != 2) ? 1 : m_ws + 2;
      efl  = ehit ? 0 : m_ws + 1;
      alloc = !ehit && (m_dis == 0) && cach && (mm != 1) && !kill;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; in_txn = 1'b1;
      lat = 1; nfl = 0;
      if (kill) begin inv_all = 1'b1; drop_model(); end
      while (!rsp_valid && lat < 20) begin
         if (fl_rd) nfl++;
         @(negedge clk);
         inv_all = 1'b0;
         lat++;
      end
      chk(rq, "latency", lat, elat);
      chk(rq, "hit flag", {63'd0, rsp_hit}, {63'd0, ehit});
      chk(rq, "data", rsp_data, pat(a, gen));
      chk(rq, "array read cycles", nfl, efl);
      if (ehit) hits_model++;
      if (rsp_hit) hits_dut++;
      if (alloc) begin mvalid[idx] = 1'b1; mtag[idx] = tg; end
      @(negedge clk);
      in_txn = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      total++; fails++;
      $display("FAIL all: watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      drop_model();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "req_ready", {63'd0, req_ready}, 1);
      chk("R1", "rsp_valid", {63'd0, rsp_valid}, 0);
      chk("R1", "fl_rd", {63'd0, fl_rd}, 0);
      rd(32'h0000_0100, 0, "R1");          // off, ws 0 at reset
      rd(32'h0000_0100, 0, "R2");          // still fetched: no allocation
      cfg(0, 0, 2);
      rd(32'h0000_0100, 0, "R5");          // miss fills
      rd(32'h0000_0104, 0, "R3");          // same line, offset ignored
      rd(32'h0000_0100, 0, "R4");          // hit
      rd(32'h0000_0300, 0, "R7");          // same index, other tag
      rd(32'h0000_0100, 0, "R7");          // evicted
      rd(32'h0040_0000, 0, "R6");          // data-flash window
      rd(32'h0040_0000, 0, "R6");
      rd(32'h0001_0000, 0, "R6");          // first byte past main array
      rd(32'h0001_0000, 0, "R6");
      rd(32'h0000_FFF8, 0, "R6");          // last main line
      rd(32'h0000_FFF8, 0, "R6");
      pulse_inv(0);
      rd(32'h0000_FFF8, 0, "R8");
      rd(32'h0000_FFF8, 0, "R8");
      pulse_inv(1);
      rd(32'h0000_FFF8, 0, "R9");          // new content after program
      rd(32'h0000_0200, 1, "R10");         // invalidate during fill
      rd(32'h0000_0200, 0, "R10");
      cfg(0, 0, 1);
      rd(32'h0000_0400, 0, "R5");
      cfg(0, 1, 1);
      rd(32'h0000_0400, 0, "R11");         // hit served
      rd(32'h0000_0408, 0, "R11");         // miss not allocated
      rd(32'h0000_0408, 0, "R11");
      cfg(0, 2, 1);
      rd(32'h0000_0400, 0, "R12");         // slow hit
      rd(32'h0000_0500, 0, "R12");
      rd(32'h0000_0500, 0, "R12");
      cfg(0, 3, 0);
      rd(32'h0000_0600, 0, "R13");
      rd(32'h0000_0600, 0, "R13");
      cfg(1, 0, 0);
      rd(32'h0000_0600, 0, "R2");          // contents not consulted
      cfg(0, 0, 0);
      rd(32'h0000_0600, 0, "R2");          // still valid from before
      for (int it = 0; it < 300; it++) begin
         logic [31:0] a;
         if (it % 50 == 0) cfg(0, (it / 50) % 2 == 0 ? 0 : 2, $urandom_range(0, 2));
         if ($urandom_range(0, 39) == 0) pulse_inv($urandom_range(0, 1) == 1);
         a = {21'd0, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 7)), 3'($urandom_range(0, 7))};
         rd(a, 1'b0, "R7");
      end
      chk("R4", "hit count", hits_dut, hits_model);
      summary();
      $finish;
   end
endmodule